// File: doc/BRIEF.md
# Nibble Decimal Display Formatter

This combinational block takes a 4-bit binary value and produces the fields a two-digit decimal readout needs. A single mode input selects how the nibble is read. When the mode input is low, the nibble is an unsigned number from 0 to 15. The block returns a tens digit, which is 0 or 1, and a units digit in BCD. When the mode input is high, the nibble is a two's complement number from -8 to +7. The block returns a negative flag and the magnitude as the units digit.

The block typically sits between an arithmetic unit and a seven-segment decoder. Two internal paths run in parallel: a one-nibble binary-to-BCD conversion and an absolute-value computation. The mode input chooses which path drives the digit output. Segment encoding and display scanning belong to other blocks.

Top module: `nibble_dec_fmt`

## Requirements
- R1: With `signed_i`=0 and `val_i` in 0..9, `tens_o`=0 and `digit_o` equals `val_i`.
- R2: With `signed_i`=0 and `val_i` in 10..15, `tens_o`=1 and `digit_o` equals `val_i` minus 10.
- R3: With `signed_i`=0, `neg_o` is 0 for every input value.
- R4: With `signed_i`=1 and `val_i[3]`=0 (values 0..7), `neg_o`=0 and `digit_o` equals `val_i`.
- R5: With `signed_i`=1 and `val_i[3]`=1, `neg_o`=1 and `digit_o` equals 16 minus `val_i`, which is the magnitude of the two's complement value.
- R6: With `signed_i`=1 and `val_i`=4'b1000 (-8), `digit_o`=8 and `neg_o`=1. The magnitude does not wrap to 0.
- R7: With `signed_i`=1, `tens_o` is 0 for every input value.
- R8: In both modes, `digit_o` is a valid decimal digit (0..9), and `tens_o` and `neg_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| val_i | input | 4 | Binary nibble to format |
| signed_i | input | 1 | 0: unsigned reading, 1: two's complement reading |
| digit_o | output | 4 | Units digit in BCD (magnitude in signed mode) |
| tens_o | output | 1 | Tens digit in unsigned mode, otherwise 0 |
| neg_o | output | 1 | Negative flag in signed mode, otherwise 0 |

## Verification
The bench applies every one of the 16 nibble values with the mode low, then every one again with the mode high.

In unsigned mode, the sweep exposes any error in where the value 9 ends and the value 10 begins, and any error in the subtract-ten correction. In signed mode, the same codes separate values whose top bit is clear, which must pass through unchanged, from values whose top bit is set, which must be negated. The code 1000 is also checked by itself, because a magnitude path that is one bit too narrow returns 0 for it instead of 8.

// File: rtl/nibble_dec_fmt.sv
module nibble_dec_fmt (
  input  logic [3:0] val_i,
  input  logic       signed_i,
  output logic [3:0] digit_o,
  output logic       tens_o,
  output logic       neg_o
);

  logic       over9;
  logic [3:0] bcd_units;
  logic [3:0] magnitude;

  assign over9     = (val_i > 4'd9);
  assign bcd_units = over9 ? (val_i - 4'd10) : val_i;
  assign magnitude = val_i[3] ? ((~val_i) + 4'd1) : val_i;

  assign digit_o = signed_i ? magnitude : bcd_units;
  assign tens_o  = ~signed_i & over9;
  assign neg_o   = signed_i & val_i[3];

endmodule

module nibble_dec_fmt_chk (
  input logic [3:0] val_i,
  input logic       signed_i,
  input logic [3:0] digit_o,
  input logic       tens_o,
  input logic       neg_o
);

  always_comb begin
    if (!signed_i)
      a_r1_r2_value_kept: assert ({1'b0, digit_o} + (tens_o ? 5'd10 : 5'd0) == {1'b0, val_i});
    if (!signed_i)
      a_r3_no_sign_unsigned: assert (!neg_o);
    if (signed_i && !neg_o)
      a_r4_positive_passthru: assert (digit_o == val_i);
    if (signed_i && neg_o)
      a_r5_r6_neg_magnitude: assert ((digit_o + val_i) == 4'd0 && digit_o != 4'd0);
    if (signed_i)
      a_r7_no_tens_signed: assert (!tens_o);
    a_r8_digit_range: assert (digit_o <= 4'd9);
    a_r8_flags_exclusive: assert (!(tens_o && neg_o));
  end

endmodule

bind nibble_dec_fmt nibble_dec_fmt_chk u_chk (
  .val_i(val_i), .signed_i(signed_i), .digit_o(digit_o),
  .tens_o(tens_o), .neg_o(neg_o)
);

// File: tb/nibble_dec_fmt_tb.sv
module nibble_dec_fmt_tb;

  logic       clk = 1'b0;
  logic [3:0] val_i = 4'd0;
  logic       signed_i = 1'b0;
  logic [3:0] digit_o;
  logic       tens_o;
  logic       neg_o;
  int         errors = 0;
  int         checks = 0;
  int         cycles = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  nibble_dec_fmt u_dut (
    .val_i(val_i), .signed_i(signed_i), .digit_o(digit_o),
    .tens_o(tens_o), .neg_o(neg_o)
  );

  task automatic check(input string req, input int exp_d, input int exp_t, input int exp_n);
    checks++;
    if (digit_o !== exp_d[3:0] || tens_o !== exp_t[0] || neg_o !== exp_n[0]) begin
      errors++;
      $display("FAIL %s mode=%0d val=%0d: got digit=%0d tens=%0d neg=%0d, expected digit=%0d tens=%0d neg=%0d",
               req, signed_i, val_i, digit_o, tens_o, neg_o, exp_d, exp_t, exp_n);
    end
  endtask

  task automatic apply_and_check(input int mode, input int v);
    int ed, et, en;
    string req;
    @(negedge clk);
    signed_i = mode[0];
    val_i = v[3:0];
    @(posedge clk);
    #1;
    if (mode == 0) begin
      en = 0;
      if (v < 10) begin ed = v;      et = 0; req = "R1/R3/R8"; end
      else        begin ed = v - 10; et = 1; req = "R2/R3/R8"; end
    end else begin
      et = 0;
      if (v < 8) begin ed = v;      en = 0; req = "R4/R7/R8"; end
      else       begin ed = 16 - v; en = 1; req = (v == 8) ? "R6/R7" : "R5/R7/R8"; end
    end
    check(req, ed, et, en);
  endtask

  initial begin
    apply_and_check(0, 0);
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 16; v++)
        apply_and_check(m, v);
    apply_and_check(1, 8);
    apply_and_check(0, 9);
    apply_and_check(0, 10);
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
  end

  initial begin
    wait (done || cycles > 1000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule